// File: doc/BRIEF.md
# Two-Range Pulse-Swallow Frequency Divider

This block divides a fast input clock by one of four ratios and produces one output period for each division cycle. A static range input selects a base length of 128 or 256 input cycles. A per-cycle modulus input, normally driven by an external swallow counter in a synthesizer loop, can stretch one division cycle by exactly sixteen input cycles.

The divider is built as a four-bit low stage that wraps every sixteen input cycles, followed by a group counter. A normal cycle runs 8 or 16 groups. A swallowing cycle runs one group more. The modulus input is captured once per division cycle, a fixed number of input cycles before the boundary, which gives the external counter a set-up window. The captured value then governs the whole of the following division cycle. The output is high for the first half of every division cycle, so each rising edge marks the start of a new cycle.

Top module: `swallow_prescaler`

## Requirements
- R1: With range_sel=1 and mod_ctl=1, every division cycle lasts 128 input clock cycles.
- R2: With range_sel=1 and mod_ctl=0, every division cycle lasts 144 input clock cycles.
- R3: With range_sel=0 and mod_ctl=1, every division cycle lasts 256 input clock cycles.
- R4: With range_sel=0 and mod_ctl=0, every division cycle lasts 272 input clock cycles.
- R5: div_out rises at the first input edge of a division cycle of length N. It is high for floor(N/2) input cycles and low for the rest.
- R6: mod_ctl is captured at the clock edge that ends position N-SAMPLE_LEAD of a division cycle (default 8 cycles before its end). That value alone sets whether the next division cycle swallows 16 extra cycles, and later changes in the same cycle have no effect on it.
- R7: When mod_ctl changes on every division cycle, the length of each cycle is the base length, plus 16 exactly when the value captured during the previous cycle was 0.
- R8: range_sel is taken only at a division-cycle boundary. A change in mid-cycle leaves the current cycle's length unchanged and applies from the next cycle.
- R9: While rst_n is low, div_out is low and the counters are cleared. div_out rises at the first clock edge after release. The first division cycle uses the control values present at that edge, so the next rise follows N-1 input cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| range_sel | input | 1 | Base length select: 1 = 128, 0 = 256 |
| mod_ctl | input | 1 | Modulus control: 0 = add 16 cycles to the next division cycle |
| div_out | output | 1 | Divided output, high for the first half of each division cycle |

## Verification
On every cycle the assertions check four things: the position counter advances by one or restarts at a boundary, the output restarts high on a boundary and falls exactly at the half point, the latched configuration stays fixed between boundaries, and the output stays low before the first clocked edge after reset. The actual ratios, the one-cycle delay in the swallow decision, and the fact that a late change of modulus is ignored depend on how the control inputs move against the output. Only the bench's scenarios show these, by counting input cycles between rising edges of the output.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

   // configuration that governs one whole division cycle
   typedef struct packed {
      logic short_range;   // 1: short base length
      logic swallow;       // 1: add one group of cycles
   } swdiv_cfg_t;

endpackage

// File: rtl/swdiv_sub_stage.sv
// low stage: wraps every 2**SUB_W input cycles
module swdiv_sub_stage #(
   parameter int SUB_W = 4
) (
   input  logic             clk_in,
   input  logic             rst_n,
   output logic [SUB_W-1:0] sub_cnt,
   output logic             sub_carry
);

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) sub_cnt <= '0;
      else        sub_cnt <= sub_cnt + 1'b1;
   end

   assign sub_carry = &sub_cnt;

endmodule

// File: rtl/swdiv_group_stage.sv
// group stage: counts low-stage wraps up to a variable last group
module swdiv_group_stage #(
   parameter int GRP_W = 5
) (
   input  logic             clk_in,
   input  logic             rst_n,
   input  logic             sub_carry,
   input  logic [GRP_W-1:0] last_grp,
   output logic [GRP_W-1:0] grp_cnt,
   output logic             terminal
);

   assign terminal = sub_carry && (grp_cnt == last_grp);

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n)         grp_cnt <= '0;
      else if (terminal)  grp_cnt <= '0;
      else if (sub_carry) grp_cnt <= grp_cnt + 1'b1;
   end

endmodule

// File: rtl/swdiv_ctl.sv
// control capture: the modulus input is taken at the sample point, range at the boundary
module swdiv_ctl
   import swdiv_pkg::*;
(
   input  logic       clk_in,
   input  logic       rst_n,
   input  logic       range_sel,
   input  logic       mod_ctl,
   input  logic       sample_hit,
   input  logic       terminal,
   output logic       fresh,
   output swdiv_cfg_t cfg_cur,
   output swdiv_cfg_t cfg_eff
);

   logic swallow_nxt;

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         fresh       <= 1'b1;
         cfg_cur     <= '0;
         swallow_nxt <= 1'b0;
      end else begin
         if (sample_hit) swallow_nxt <= ~mod_ctl;
         if (fresh) begin
            fresh               <= 1'b0;
            cfg_cur.short_range <= range_sel;
            cfg_cur.swallow     <= ~mod_ctl;
         end else if (terminal) begin
            cfg_cur.short_range <= range_sel;
            cfg_cur.swallow     <= swallow_nxt;
         end
      end
   end

   // until the first edge after reset, the live inputs set the first cycle
   always_comb begin
      if (fresh) begin
         cfg_eff.short_range = range_sel;
         cfg_eff.swallow     = ~mod_ctl;
      end else begin
         cfg_eff = cfg_cur;
      end
   end

endmodule

// File: rtl/swallow_prescaler.sv
module swallow_prescaler
   import swdiv_pkg::*;
#(
   parameter int SUB_W       = 4,
   parameter int LOW_GROUPS  = 8,
   parameter int HIGH_GROUPS = 16,
   parameter int SAMPLE_LEAD = 8
) (
   input  logic clk_in,
   input  logic rst_n,
   input  logic range_sel,
   input  logic mod_ctl,
   output logic div_out
);

   localparam int MAX_GROUPS = HIGH_GROUPS + 1;
   localparam int GRP_W      = $clog2(MAX_GROUPS + 1);
   localparam int P_W        = SUB_W + GRP_W;
   localparam int TOT_W      = P_W + 1;

   generate
      if (SUB_W < 2)                  $error("SUB_W must be at least 2");
      if (LOW_GROUPS < 1)             $error("LOW_GROUPS must be at least 1");
      if (HIGH_GROUPS <= LOW_GROUPS)  $error("HIGH_GROUPS must exceed LOW_GROUPS");
      if (SAMPLE_LEAD < 1)            $error("SAMPLE_LEAD must be at least 1");
      if (SAMPLE_LEAD >= (LOW_GROUPS << SUB_W))
                                      $error("SAMPLE_LEAD must fall inside the shortest cycle");
   endgenerate

   logic [SUB_W-1:0] sub_cnt;
   logic             sub_carry;
   logic [GRP_W-1:0] grp_cnt;
   logic [GRP_W-1:0] last_grp;
   logic             terminal;
   logic             fresh;
   logic             sample_hit;
   swdiv_cfg_t       cfg_cur;
   swdiv_cfg_t       cfg_eff;
   logic [P_W-1:0]   pos;
   logic [TOT_W-1:0] groups_eff;
   logic [TOT_W-1:0] total_eff;
   logic [TOT_W-1:0] half_eff;
   logic             out_d;

   swdiv_sub_stage #(.SUB_W(SUB_W)) u_sub (
      .clk_in    (clk_in),
      .rst_n     (rst_n),
      .sub_cnt   (sub_cnt),
      .sub_carry (sub_carry)
   );

   swdiv_group_stage #(.GRP_W(GRP_W)) u_grp (
      .clk_in    (clk_in),
      .rst_n     (rst_n),
      .sub_carry (sub_carry),
      .last_grp  (last_grp),
      .grp_cnt   (grp_cnt),
      .terminal  (terminal)
   );

   swdiv_ctl u_ctl (
      .clk_in     (clk_in),
      .rst_n      (rst_n),
      .range_sel  (range_sel),
      .mod_ctl    (mod_ctl),
      .sample_hit (sample_hit),
      .terminal   (terminal),
      .fresh      (fresh),
      .cfg_cur    (cfg_cur),
      .cfg_eff    (cfg_eff)
   );

   // group size is a power of two, so the position is the two counts side by side
   assign pos = {grp_cnt, sub_cnt};

   always_comb begin
      groups_eff = cfg_eff.short_range ? TOT_W'(LOW_GROUPS) : TOT_W'(HIGH_GROUPS);
      if (cfg_eff.swallow) groups_eff = groups_eff + 1'b1;
      total_eff  = groups_eff << SUB_W;
      half_eff   = total_eff >> 1;
   end

   assign last_grp   = GRP_W'(groups_eff - 1'b1);
   assign sample_hit = (TOT_W'(pos) == (total_eff - TOT_W'(SAMPLE_LEAD)));

   // output holds the comparison for the position entered on this edge
   always_comb begin
      if (terminal) out_d = 1'b1;
      else          out_d = ((TOT_W'(pos) + 1'b1) < half_eff);
   end

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) div_out <= 1'b0;
      else        div_out <= out_d;
   end

endmodule

// File: rtl/swdiv_checker.sv
module swdiv_checker
   import swdiv_pkg::*;
#(
   parameter int P_W   = 9,
   parameter int TOT_W = 10
) (
   input logic             clk_in,
   input logic             rst_n,
   input logic             div_out,
   input logic [P_W-1:0]   pos,
   input logic [TOT_W-1:0] total_eff,
   input logic [TOT_W-1:0] half_eff,
   input logic             terminal,
   input logic             fresh,
   input swdiv_cfg_t       cfg_cur
);

   AST_RESTART_HIGH: assert property (@(posedge clk_in) disable iff (!rst_n)
      terminal |=> (div_out && pos == '0));                                   // R5

   AST_FALL_AT_HALF: assert property (@(posedge clk_in) disable iff (!rst_n)
      $fell(div_out) |-> (TOT_W'(pos) == half_eff));                         // R5

   AST_POS_STEP: assert property (@(posedge clk_in) disable iff (!rst_n)
      !terminal |=> (pos == $past(pos) + 1'b1));                             // R7

   AST_POS_BOUND: assert property (@(posedge clk_in) disable iff (!rst_n)
      TOT_W'(pos) < total_eff);                                              // R7

   AST_CFG_HELD: assert property (@(posedge clk_in) disable iff (!rst_n)
      (!terminal && !fresh) |=> $stable(cfg_cur));                           // R8

   AST_FRESH_LOW: assert property (@(posedge clk_in) disable iff (!rst_n)
      fresh |-> (!div_out && pos == '0));                                    // R9

endmodule

bind swallow_prescaler swdiv_checker #(.P_W(P_W), .TOT_W(TOT_W)) u_chk (
   .clk_in    (clk_in),
   .rst_n     (rst_n),
   .div_out   (div_out),
   .pos       (pos),
   .total_eff (total_eff),
   .half_eff  (half_eff),
   .terminal  (terminal),
   .fresh     (fresh),
   .cfg_cur   (cfg_cur)
);

// File: tb/test_swallow_prescaler.sv
module test_swallow_prescaler;

   logic clk_in = 1'b0;
   logic rst_n  = 1'b0;
   logic range_sel = 1'b1;
   logic mod_ctl   = 1'b1;
   logic div_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic prev_o = 1'b0;
   logic rise_seen = 1'b0;
   logic done = 1'b0;

   always #2 clk_in = ~clk_in;

   swallow_prescaler i_swallow_prescaler (
      .clk_in    (clk_in),
      .rst_n     (rst_n),
      .range_sel (range_sel),
      .mod_ctl   (mod_ctl),
      .div_out   (div_out)
   );

   always @(posedge clk_in) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles expected under 150000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk_in);
      rise_seen = div_out && !prev_o;
      prev_o    = div_out;
   endtask

   task automatic next_rise(output int n, output int hi);
      n = 0;
      hi = 0;
      do begin
         tick();
         n++;
         if (div_out) hi++;
      end while (!rise_seen);
   endtask

   task automatic do_reset(input logic rs, input logic mc);
      int n;
      int hi;
      rst_n = 1'b0;
      range_sel = rs;
      mod_ctl = mc;
      for (int i = 0; i < 3; i++) tick();
      check("R9 output low in reset", int'(div_out), 0);
      rst_n = 1'b1;
      next_rise(n, hi);
      check("R9 first rise after release", n, 1);
   endtask

   task automatic test_static(input logic rs, input logic mc, input int len, input string req);
      int n;
      int hi;
      do_reset(rs, mc);
      next_rise(n, hi);
      check("R9 first cycle from release values", n, len - 1);
      for (int k = 0; k < 2; k++) begin
         next_rise(n, hi);
         check(req, n, len);
         check("R5 high time", hi, len / 2);
      end
   endtask

   task automatic test_toggle(input logic rs);
      int n;
      int hi;
      int base;
      int exp;
      logic prev_mod;
      base = rs ? 128 : 256;
      do_reset(rs, 1'b1);
      prev_mod = 1'b1;
      for (int i = 0; i < 6; i++) begin
         mod_ctl = (i % 2 == 0) ? 1'b0 : 1'b1;
         next_rise(n, hi);
         exp = (prev_mod ? base : base + 16) - ((i == 0) ? 1 : 0);
         check("R7 toggling length", n, exp);
         prev_mod = mod_ctl;
      end
   endtask

   task automatic test_late();
      int n;
      int hi;
      do_reset(1'b1, 1'b1);
      next_rise(n, hi);
      check("R9 first cycle", n, 127);
      // now at position 0 of a 128 cycle
      for (int i = 0; i < 10; i++) tick();
      range_sel = 1'b0;
      for (int i = 0; i < 114; i++) tick();
      mod_ctl = 1'b0;       // position 124, past the sample point
      next_rise(n, hi);
      check("R8 mid-cycle range change keeps length", n + 124, 128);
      next_rise(n, hi);
      check("R6 late modulus change ignored", n, 256);
      next_rise(n, hi);
      check("R6 modulus change taken next sample", n, 272);
      check("R5 high time 272", hi, 136);
   endtask

   initial begin
      test_static(1'b1, 1'b1, 128, "R1 ratio 128");
      test_static(1'b1, 1'b0, 144, "R2 ratio 144");
      test_static(1'b0, 1'b1, 256, "R3 ratio 256");
      test_static(1'b0, 1'b0, 272, "R4 ratio 272");
      test_toggle(1'b1);
      test_toggle(1'b0);
      test_late();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule